// File: doc/BRIEF.md
# Thermal Clock Modulation Throttle

This block throttles a core by switching its clock-enable on and off inside a fixed time window. It is the last resort of thermal control. Frequency and voltage reduction is tried first. The block only starts modulating once control is active and the frequency and voltage targets have reached their floor. The window is measured in pulses of a free-running reference tick, so its length in absolute time does not depend on the core clock. With a 100 MHz tick, the default of 3200 ticks gives a 32 µs window.

The duty is taken from a 3-bit throttle-need level N. Within each window the enable is high for the first N/8 of the window and low for the rest, so delivered performance scales by N/8. A new need level is taken up only at a window boundary. Software has no path to override the duty.

An over-temperature flag turns control on. When the flag clears, control stays on until a hysteresis timer has counted a set number of reference ticks. If the flag returns during that time, the timer starts again from zero. Whenever control is off, or the targets are above their floor, the enable is held high.

Top module: `thermal_clkmod`

## Requirements
- R1: During and after reset, before any over-temperature, clk_en is 1, ctl_active is 0 and duty_code is 0.
- R2: A cycle with over_temp high makes ctl_active 1 on the next clock.
- R3: While vf_at_floor is 0, clk_en stays 1 and duty_code reads 0, even if control is active.
- R4: Two clocks after over_temp and vf_at_floor are raised together, duty_code shows the sampled need level and modulation starts at window position 0.
- R5: With duty code N (1..7), a window of PERIOD_TICKS reference ticks contains exactly N*PERIOD_TICKS/8 ticks with clk_en high, and all of them come before any tick with clk_en low.
- R6: A need level of 0 is taken as duty code 1.
- R7: A change of need_level during a window has no effect until the next window. The current window keeps the old on-count, and the following window uses the new one.
- R8: After over_temp falls, ctl_active stays 1 for exactly HYST_TICKS reference ticks and then falls. One clock later clk_en is 1 and duty_code is 0.
- R9: Raising over_temp again during the hysteresis interval restarts the count, so HYST_TICKS full ticks are needed again after it clears.
- R10: Dropping vf_at_floor while modulating stops modulation on the next clock. ctl_active stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low synchronous reset |
| ref_tick | input | 1 | one-cycle pulse from the fixed-rate reference |
| over_temp | input | 1 | temperature at or above the limit |
| vf_at_floor | input | 1 | frequency and voltage targets at their minimum |
| need_level | input | 3 | throttle need, 0..7 |
| clk_en | output | 1 | core clock-enable |
| ctl_active | output | 1 | thermal control episode in progress |
| duty_code | output | 3 | duty in eighths while modulating, else 0 |

## Verification
The bench builds the block with a 16-tick window and a 5-tick hysteresis. Each eighth of the window is then two ticks, so every duty code from 0 to 7 can be swept and whole windows counted tick by tick within a short run. The small hysteresis lets the bench measure the exact exit delay and its restart. The reference tick fires every third clock, which keeps clock counts and tick counts clearly apart.

// File: rtl/thermal_clkmod.sv
module thermal_clkmod #(
  parameter int unsigned PERIOD_TICKS = 3200,
  parameter int unsigned DUTY_W       = 3,
  parameter int unsigned HYST_TICKS   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              over_temp,
  input  logic              vf_at_floor,
  input  logic [DUTY_W-1:0] need_level,
  output logic              clk_en,
  output logic              ctl_active,
  output logic [DUTY_W-1:0] duty_code
);
  localparam int unsigned PH_W  = $clog2(PERIOD_TICKS);
  localparam int unsigned HY_W  = $clog2(HYST_TICKS + 1);
  localparam int unsigned SLICE = PERIOD_TICKS >> DUTY_W;

  logic              active;
  logic [HY_W-1:0]   hcnt;
  logic              run;
  logic [PH_W-1:0]   phase;
  logic [DUTY_W-1:0] duty;
  logic [PH_W:0]     on_len;

  wire engage = active & vf_at_floor;
  wire [DUTY_W-1:0] need_c = (need_level == '0) ? DUTY_W'(1) : need_level;
  wire wrap = (phase == PH_W'(PERIOD_TICKS - 1));

  assign on_len     = (PH_W+1)'(duty) * (PH_W+1)'(SLICE);
  assign clk_en     = ~run | ({1'b0, phase} < on_len);
  assign duty_code  = run ? duty : '0;
  assign ctl_active = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      hcnt   <= '0;
    end else if (over_temp) begin
      active <= 1'b1;
      hcnt   <= '0;
    end else if (active && ref_tick) begin
      if (hcnt == HY_W'(HYST_TICKS - 1)) begin
        active <= 1'b0;
        hcnt   <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= '0;
      duty  <= '0;
    end else if (!engage) begin
      run   <= 1'b0;
      phase <= '0;
    end else if (!run) begin
      run   <= 1'b1;
      phase <= '0;
      duty  <= need_c;
    end else if (ref_tick) begin
      if (wrap) begin
        phase <= '0;
        duty  <= need_c;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

module thermal_clkmod_chk #(
  parameter int unsigned PH_W   = 12,
  parameter int unsigned DUTY_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              over_temp,
  input logic              vf_at_floor,
  input logic              clk_en,
  input logic              ctl_active,
  input logic [DUTY_W-1:0] duty_code,
  input logic [PH_W-1:0]   phase
);
  // R2
  enter_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> ctl_active);

  // R3
  no_mod_above_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_at_floor |=> (clk_en && duty_code == '0));

  // R8
  idle_enable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_active |=> clk_en);

  // R8
  exit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_active) |-> ($past(!over_temp) && $past(ref_tick)));

  // R7
  duty_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_code != '0 && $past(duty_code) != '0 && duty_code != $past(duty_code))
      |-> (phase == '0 && $past(ref_tick)));

  // R5
  on_phase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_code != '0 && phase == '0) |-> clk_en);
endmodule

bind thermal_clkmod thermal_clkmod_chk #(.PH_W(PH_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .over_temp(over_temp),
  .vf_at_floor(vf_at_floor), .clk_en(clk_en), .ctl_active(ctl_active),
  .duty_code(duty_code), .phase(phase)
);

// File: tb/test_thermal_clkmod.sv
`timescale 1ns/1ps
module test_thermal_clkmod;
  localparam int P = 16;
  localparam int H = 5;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0;
  logic over_temp = 1'b0, vf_at_floor = 1'b0;
  logic [2:0] need_level = 3'd0;
  logic clk_en, ctl_active;
  logic [2:0] duty_code;

  int errors = 0, checks = 0, div = 0;

  always #4 clk = ~clk;

  thermal_clkmod #(.PERIOD_TICKS(P), .DUTY_W(3), .HYST_TICKS(H)) i_thermal_clkmod (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .over_temp(over_temp),
    .vf_at_floor(vf_at_floor), .need_level(need_level), .clk_en(clk_en),
    .ctl_active(ctl_active), .duty_code(duty_code));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; over_temp = 1'b0; vf_at_floor = 1'b0; need_level = 3'd0; ref_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic bit next_tick();
    div++;
    return (div % 3) == 0;
  endfunction

  task automatic measure(input int n, output int on, output bit ordered);
    int idx = 0;
    bit seen_off = 1'b0;
    on = 0; ordered = 1'b1;
    while (idx < n) begin
      @(negedge clk);
      if (next_tick()) begin
        if (clk_en) begin on++; if (seen_off) ordered = 1'b0; end
        else seen_off = 1'b1;
        idx++;
        ref_tick = 1'b1;
      end else ref_tick = 1'b0;
    end
  endtask

  task automatic engage(input logic [2:0] n, output int lat);
    @(negedge clk);
    over_temp = 1'b1; vf_at_floor = 1'b1; need_level = n; ref_tick = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      ref_tick = 1'b0;
      lat++;
    end while (duty_code == 3'd0 && lat < 20);
  endtask

  task automatic exit_count(output int k);
    k = 0;
    for (int g = 0; g < 300; g++) begin
      @(negedge clk);
      if (!ctl_active) break;
      ref_tick = next_tick();
      if (ref_tick) k++;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int on, lat, k;
    bit ord;

    @(negedge clk); @(negedge clk);
    chk(clk_en === 1'b1, "R1", "clk_en in reset", clk_en, 1);
    chk(ctl_active === 1'b0, "R1", "ctl_active in reset", ctl_active, 0);
    chk(duty_code === 3'd0, "R1", "duty in reset", duty_code, 0);
    do_reset();
    @(negedge clk);
    chk(clk_en === 1'b1 && ctl_active === 1'b0, "R1", "idle after reset", {ctl_active, clk_en}, 1);

    // R2, R3: control active but targets above floor
    over_temp = 1'b1; need_level = 3'd5;
    @(negedge clk);
    chk(ctl_active === 1'b1, "R2", "ctl_active one clock later", ctl_active, 1);
    measure(2 * P, on, ord);
    chk(on == 2 * P, "R3", "enabled ticks above floor", on, 2 * P);
    chk(duty_code == 3'd0, "R3", "duty above floor", duty_code, 0);

    // R4, R5: sweep of every duty code
    for (int n = 1; n <= 7; n++) begin
      do_reset();
      engage(3'(n), lat);
      chk(lat == 2, "R4", "engage latency", lat, 2);
      chk(duty_code == 3'(n), "R4", "sampled duty", duty_code, n);
      for (int w = 0; w < 2; w++) begin
        measure(P, on, ord);
        chk(on == n * P / 8, "R5", "on ticks per window", on, n * P / 8);
        chk(ord, "R5", "on phase first", ord, 1);
      end
    end

    // R6
    do_reset();
    engage(3'd0, lat);
    chk(duty_code == 3'd1, "R6", "need 0 clamps to 1", duty_code, 1);
    measure(P, on, ord);
    chk(on == P / 8, "R6", "on ticks for need 0", on, P / 8);

    // R7
    do_reset();
    engage(3'd2, lat);
    need_level = 3'd6;
    measure(P, on, ord);
    chk(on == 2 * P / 8, "R7", "old duty kept in window", on, 2 * P / 8);
    chk(duty_code == 3'd2, "R7", "duty before boundary", duty_code, 2);
    measure(P, on, ord);
    chk(on == 6 * P / 8, "R7", "new duty next window", on, 6 * P / 8);
    chk(duty_code == 3'd6, "R7", "duty after boundary", duty_code, 6);

    // R8
    do_reset();
    engage(3'd3, lat);
    measure(5, on, ord);
    @(negedge clk);
    over_temp = 1'b0; ref_tick = 1'b0;
    exit_count(k);
    chk(k == H, "R8", "hysteresis ticks", k, H);
    ref_tick = 1'b0;
    @(negedge clk);
    chk(clk_en === 1'b1, "R8", "clk_en after exit", clk_en, 1);
    chk(duty_code == 3'd0, "R8", "duty after exit", duty_code, 0);

    // R9
    do_reset();
    engage(3'd4, lat);
    @(negedge clk);
    over_temp = 1'b0; ref_tick = 1'b0;
    k = 0;
    while (k < H - 1) begin
      @(negedge clk);
      ref_tick = next_tick();
      if (ref_tick) k++;
    end
    @(negedge clk);
    chk(ctl_active === 1'b1, "R9", "active before restart", ctl_active, 1);
    over_temp = 1'b1; ref_tick = 1'b0;
    @(negedge clk);
    over_temp = 1'b0; ref_tick = 1'b0;
    exit_count(k);
    chk(k == H, "R9", "ticks after restart", k, H);

    // R10
    do_reset();
    engage(3'd4, lat);
    measure(3, on, ord);
    @(negedge clk);
    vf_at_floor = 1'b0; ref_tick = 1'b0;
    @(negedge clk);
    chk(clk_en === 1'b1, "R10", "clk_en after floor lost", clk_en, 1);
    chk(duty_code == 3'd0, "R10", "duty after floor lost", duty_code, 0);
    chk(ctl_active === 1'b1, "R10", "control stays active", ctl_active, 1);
    measure(P, on, ord);
    chk(on == P, "R10", "no modulation above floor", on, P);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule